// File: doc/BRIEF.md
# Microcoded Datapath ALU and Shifter

This block is the arithmetic stage of a bus-based microcoded datapath. It takes one 32-bit operand from a holding register and one from a shared source bus. It computes a result that is chosen by a small set of independent control lines rather than by an opcode. That result goes through a shifter and leaves on a result bus, which the surrounding datapath can write to any register in the same cycle that the operands were read.

Two function-select bits choose AND, OR, NOT of the bus operand, or a sum. Each operand has its own enable. A disabled operand is forced to zero before the invert stage. The holding-register operand can be inverted, and a carry-in line adds one to the sum. These lines let a single adder produce a plain copy, an increment, a negation, a subtraction and similar results. Two shifter lines select a left shift by one byte or an arithmetic right shift by one bit.

Two flags record whether the unshifted ALU output is negative or zero. They are captured at a clock edge when a flag-enable strobe is high. Microcode uses them to choose a branch target.

Top module: `asx_alu_shift`

## Requirements
- R1: An operand whose enable is low enters the function stage as zero, and this happens before the invert step. With `opa_en`=0 and `opa_inv`=1, the conditioned holding-register operand is all ones.
- R2: With `fn_sel`=2'b11, the ALU output is the 32-bit sum of the conditioned A operand, the conditioned B operand and `carry_in`, taken modulo 2^32. Some cases: A+B, A+1 (only A enabled, carry set), -A (A inverted, carry set) and B-A (both enabled, A inverted, carry set).
- R3: `fn_sel`=2'b00 gives the bitwise AND of the two conditioned operands. `fn_sel`=2'b01 gives their bitwise OR.
- R4: `fn_sel`=2'b10 gives the bitwise NOT of the conditioned B operand.
- R5: `carry_in` has no effect when `fn_sel` selects a logic function (2'b00, 2'b01 or 2'b10).
- R6: With only `shl_byte` high, the result bus is the ALU output shifted left by 8 bits, with zeros filling the low byte. With only `sar_one` high, it is the ALU output shifted right by 1 bit, with the sign bit copied into the top bit. With neither high, it equals the ALU output.
- R7: With both `shl_byte` and `sar_one` high, the result bus equals the unshifted ALU output.
- R8: On a rising clock edge with `flag_we` high, `flag_neg` takes bit 31 of the ALU output before shifting, and `flag_zero` is set exactly when that output is all zeros.
- R9: On a rising clock edge with `flag_we` low, both flags keep their values.
- R10: While `rst_n` is low, both flags are cleared at once, without waiting for a clock edge.
- R11: The result bus is combinational in the operands and controls. A register can therefore be read and its new value presented for write-back in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag flip-flops |
| rst_n | input | 1 | Asynchronous active-low reset |
| opa | input | 32 | Operand from the holding register |
| opb | input | 32 | Operand from the shared source bus |
| fn_sel | input | 2 | Function select: 00 AND, 01 OR, 10 NOT B, 11 sum |
| opa_en | input | 1 | Pass the A operand (forced to zero when low) |
| opb_en | input | 1 | Pass the B operand (forced to zero when low) |
| opa_inv | input | 1 | Invert the conditioned A operand |
| carry_in | input | 1 | Add one to the sum |
| shl_byte | input | 1 | Shift the result left by 8 bits |
| sar_one | input | 1 | Shift the result right arithmetically by 1 bit |
| flag_we | input | 1 | Capture the flags at this clock edge |
| res_bus | output | 32 | Shifted result onto the write-back bus |
| flag_neg | output | 1 | Registered negative flag |
| flag_zero | output | 1 | Registered zero flag |

## Verification
The assertions check several rules on every cycle:
- The flags capture the pre-shift sign and zero state whenever the strobe is high, and hold when it is low.
- The low byte is zero-filled on a left shift, and the sign bit is kept on a right shift.
- The result passes through unchanged when both shift lines are high.
- An AND result never has a bit set outside the conditioned B operand.

The exact arithmetic values can only be shown by the bench's vector scenarios. These include negation, subtraction, operand gating ahead of the inverter and the absence of any carry effect on logic functions. The flags taken from the pre-shift value when the shifted result differs, and the asynchronous clear, are likewise shown only by the bench's directed scenarios.

// File: rtl/asx_pkg.sv
package asx_pkg;
  typedef enum logic [1:0] {
    FN_AND  = 2'b00,
    FN_OR   = 2'b01,
    FN_NOTB = 2'b10,
    FN_SUM  = 2'b11
  } asx_fn_e;
endpackage

// File: rtl/asx_operand_cond.sv
module asx_operand_cond #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         a_en,
  input  logic         b_en,
  input  logic         a_inv,
  output logic [W-1:0] a_cond,
  output logic [W-1:0] b_cond
);
  logic [W-1:0] a_gated;

  // R1: gate first, then invert
  always_comb begin
    a_gated = a_en ? a_in : '0;
    a_cond  = a_gated ^ {W{a_inv}};
    b_cond  = b_en ? b_in : '0;
  end
endmodule

// File: rtl/asx_func_unit.sv
module asx_func_unit
  import asx_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a_cond,
  input  logic [W-1:0] b_cond,
  input  asx_fn_e      fn,
  input  logic         cin,
  output logic [W-1:0] y
);
  logic [W-1:0] sum;

  always_comb begin
    sum = a_cond + b_cond + {{(W-1){1'b0}}, cin};
    unique case (fn)
      FN_AND:  y = a_cond & b_cond;
      FN_OR:   y = a_cond | b_cond;
      FN_NOTB: y = ~b_cond;
      default: y = sum;
    endcase
  end
endmodule

// File: rtl/asx_shifter.sv
module asx_shifter #(
  parameter int W     = 32,
  parameter int LSHFT = 8
) (
  input  logic [W-1:0] d,
  input  logic         shl,
  input  logic         sar,
  output logic [W-1:0] q
);
  always_comb begin
    unique case ({shl, sar})
      2'b10:   q = {d[W-1-LSHFT:0], {LSHFT{1'b0}}};
      2'b01:   q = {d[W-1], d[W-1:1]};
      default: q = d;  // neither or both: pass through (R7)
    endcase
  end
endmodule

// File: rtl/asx_flag_reg.sv
module asx_flag_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] y,
  output logic         neg,
  output logic         zero
);
  logic neg_d, zero_d;

  always_comb begin
    neg_d  = neg;
    zero_d = zero;
    if (we) begin
      neg_d  = y[W-1];
      zero_d = (y == '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      neg  <= 1'b0;
      zero <= 1'b0;
    end else begin
      neg  <= neg_d;
      zero <= zero_d;
    end
  end

  p_flags_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable({neg, zero}))
    else $error("flags changed without strobe");
endmodule

// File: rtl/asx_alu_shift.sv
module asx_alu_shift
  import asx_pkg::*;
#(
  parameter int W     = 32,
  parameter int LSHFT = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic [1:0]   fn_sel,
  input  logic         opa_en,
  input  logic         opb_en,
  input  logic         opa_inv,
  input  logic         carry_in,
  input  logic         shl_byte,
  input  logic         sar_one,
  input  logic         flag_we,
  output logic [W-1:0] res_bus,
  output logic         flag_neg,
  output logic         flag_zero
);
  logic [W-1:0] a_c, b_c, alu_y;
  asx_fn_e      fn;

  assign fn = asx_fn_e'(fn_sel);

  asx_operand_cond #(.W(W)) u_cond (
    .a_in(opa), .b_in(opb), .a_en(opa_en), .b_en(opb_en), .a_inv(opa_inv),
    .a_cond(a_c), .b_cond(b_c)
  );

  asx_func_unit #(.W(W)) u_fu (
    .a_cond(a_c), .b_cond(b_c), .fn(fn), .cin(carry_in), .y(alu_y)
  );

  asx_shifter #(.W(W), .LSHFT(LSHFT)) u_sh (
    .d(alu_y), .shl(shl_byte), .sar(sar_one), .q(res_bus)
  );

  asx_flag_reg #(.W(W)) u_flg (
    .clk(clk), .rst_n(rst_n), .we(flag_we), .y(alu_y),
    .neg(flag_neg), .zero(flag_zero)
  );

  p_neg_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |=> flag_neg == $past(alu_y[W-1]))
    else $error("negative flag not captured");

  p_zero_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |=> flag_zero == ($past(alu_y) == '0))
    else $error("zero flag not captured");

  p_both_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (shl_byte && sar_one) |-> res_bus == alu_y)
    else $error("both shift lines did not pass through");

  p_sll_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (shl_byte && !sar_one) |-> res_bus[LSHFT-1:0] == '0)
    else $error("left shift low byte not zero");

  p_sra_sign_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sar_one && !shl_byte) |-> res_bus[W-1] == alu_y[W-1])
    else $error("right shift lost sign");

  p_and_subset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fn_sel == 2'b00) |-> (alu_y & ~b_c) == '0)
    else $error("AND result outside B operand");
endmodule

// File: tb/tb_asx_alu_shift.sv
module tb_asx_alu_shift;
  localparam int W = 32;
  localparam int NV = 17;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] opa, opb;
  logic [1:0]   fn_sel;
  logic         opa_en, opb_en, opa_inv, carry_in, shl_byte, sar_one, flag_we;
  logic [W-1:0] res_bus;
  logic         flag_neg, flag_zero;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  asx_alu_shift dut (
    .clk(clk), .rst_n(rst_n), .opa(opa), .opb(opb), .fn_sel(fn_sel),
    .opa_en(opa_en), .opb_en(opb_en), .opa_inv(opa_inv), .carry_in(carry_in),
    .shl_byte(shl_byte), .sar_one(sar_one), .flag_we(flag_we),
    .res_bus(res_bus), .flag_neg(flag_neg), .flag_zero(flag_zero)
  );

  // {opa, opb, fn_sel, {a_en,b_en,a_inv,cin,shl,sar}, expected res_bus}
  localparam logic [103:0] VEC [NV] = '{
    {32'h00000005, 32'h00000003, 2'b11, 6'b110000, 32'h00000008}, // R2 A+B
    {32'h00000005, 32'h00000003, 2'b11, 6'b100100, 32'h00000006}, // R2 A+1
    {32'h00000005, 32'h00000003, 2'b11, 6'b101100, 32'hFFFFFFFB}, // R2 -A
    {32'h00000005, 32'h00000003, 2'b11, 6'b111100, 32'hFFFFFFFE}, // R2 B-A
    {32'h00000005, 32'h00000003, 2'b00, 6'b110000, 32'h00000001}, // R3 AND
    {32'h00000005, 32'h00000003, 2'b01, 6'b110000, 32'h00000007}, // R3 OR
    {32'h00000005, 32'h00000003, 2'b10, 6'b010000, 32'hFFFFFFFC}, // R4 NOT B
    {32'h00000005, 32'h00000003, 2'b10, 6'b000000, 32'hFFFFFFFF}, // R4 NOT gated B
    {32'h00000005, 32'h00000003, 2'b11, 6'b011000, 32'h00000002}, // R1 gate before invert
    {32'h00000005, 32'h00000003, 2'b00, 6'b110100, 32'h00000001}, // R5 AND with cin
    {32'h00000005, 32'h00000003, 2'b01, 6'b110100, 32'h00000007}, // R5 OR with cin
    {32'h12345678, 32'h00000000, 2'b11, 6'b100010, 32'h34567800}, // R6 left byte
    {32'h80000010, 32'h00000000, 2'b11, 6'b100001, 32'hC0000008}, // R6 sar negative
    {32'h00000011, 32'h00000000, 2'b11, 6'b100001, 32'h00000008}, // R6 sar positive
    {32'h12345678, 32'h00000000, 2'b11, 6'b100011, 32'h12345678}, // R7 both
    {32'hF0F0F0F0, 32'hFF00FF00, 2'b00, 6'b110001, 32'hF8007800}, // R6 AND then sar
    {32'h00000005, 32'h00000003, 2'b10, 6'b010100, 32'hFFFFFFFC}  // R5 NOT B with cin
  };

  function automatic string req_of(int i);
    case (i)
      0, 1, 2, 3:     return "R2";
      4, 5:           return "R3";
      6, 7:           return "R4";
      8:              return "R1";
      9, 10, 16:      return "R5";
      14:             return "R7";
      default:        return "R6";
    endcase
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b, input logic [1:0] f,
                       input logic [5:0] c);
    opa = a; opb = b; fn_sel = f;
    {opa_en, opb_en, opa_inv, carry_in, shl_byte, sar_one} = c;
  endtask

  initial begin
    #3_000_000;
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; flag_we = 1'b0;
    drive('0, '0, 2'b00, 6'b000000);
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10", {30'b0, flag_neg, flag_zero}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R11: combinational result read in the same cycle, vector walk
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][103:72], VEC[i][71:40], VEC[i][39:38], VEC[i][37:32]);
      #1;
      check(req_of(i), res_bus, VEC[i][31:0]);
    end
    // R11: change takes effect with no clock edge
    drive(32'h00000009, 32'h00000001, 2'b11, 6'b110000);
    #1 check("R11", res_bus, 32'h0000000A);

    // R8: zero result captures Z=1, N=0
    @(negedge clk);
    drive(32'h0, 32'h0, 2'b11, 6'b100000);
    flag_we = 1'b1;
    @(negedge clk);
    check("R8", {30'b0, flag_neg, flag_zero}, 32'h1);

    // R8: flags from pre-shift value (shifted result is zero, ALU output negative)
    drive(32'h80000000, 32'h0, 2'b11, 6'b100010);
    #1 check("R6", res_bus, 32'h0);
    @(negedge clk);
    check("R8", {30'b0, flag_neg, flag_zero}, 32'h2);

    // R9: strobe low, zero result must not move the flags
    flag_we = 1'b0;
    drive(32'h0, 32'h0, 2'b11, 6'b100000);
    repeat (2) @(negedge clk);
    check("R9", {30'b0, flag_neg, flag_zero}, 32'h2);

    // R10: asynchronous clear between edges
    #3 rst_n = 1'b0;
    #2 check("R10", {30'b0, flag_neg, flag_zero}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule